// File: doc/BRIEF.md
# Event Timer Register File

This block is the shared front end of a multi-channel event timer. It owns a 64-bit main counter, a global configuration register and a read-only capability word. It decodes a 1 KB window of 32-bit registers. Accesses to the upper three quarters of the window are passed to per-channel register groups through a one-hot select, an offset and the write data. Each channel's read data comes back through the same read path. The counter value, the global enable and the legacy-routing mode are driven to every channel.

The counter has a two-state controller. In `CTR_HALTED` the counter holds its value and software may preset either 32-bit half. In `CTR_RUNNING` it advances by one on every cycle in which `cnt_tick` is high. The START transition (`CTR_HALTED` to `CTR_RUNNING`) is taken when a configuration write sets the enable bit. It sends a one-cycle arm strobe to every channel whose comparator is valid. The STOP transition (`CTR_RUNNING` to `CTR_HALTED`) is taken when a configuration write clears the enable bit. It freezes the counter and sends a one-cycle disarm strobe. The legacy bit drives an output that tells the legacy timers to stand down.

Requests are single-cycle: `req_valid` with `req_write`, address and data. A read answers on the following cycle with `rsp_valid` and `rsp_rdata`. A write gives no response.

Top module: `evt_timer_regs`

## Requirements
- R1: An aligned address from 0x100 to 0x3FF selects channel (addr-0x100)>>5 with offset addr[4:0]. For a channel below NUM_CH, `chan_sel` is one-hot for that cycle and a read returns that channel's `chan_rdata` slice. For a higher index no select is raised and a read returns zero.
- R2: A read raises `rsp_valid` exactly one cycle after the request, with the data. A write never raises `rsp_valid`.
- R3: Offset 0x000 reads {16'h8086, bit15=1 legacy capable, bit14=0, bit13=1 64-bit counter, bits12:8=NUM_CH-1, 8'h01}, which is 0x8086A201 with the defaults. Offset 0x004 reads TICK_FS (default 10000000). Writes to either offset are ignored.
- R4: The configuration register is at 0x010. Only bits set in CFG_WMASK (bits 1:0) change on a write. Offset 0x014 reads zero and ignores writes.
- R5: While configuration bit 0 (enable) is clear, the counter holds. While it is set, the counter adds one per cycle with `cnt_tick` high. It counts on each edge after the enabling write, up to and including the edge of the disabling write.
- R6: The counter low half (0x0F0) and high half (0x0F4) are written independently while halted, and each write changes only its own half. Counter writes while running are ignored.
- R7: An enable 0-to-1 write pulses `arm_strobe` for one cycle, equal to `chan_cmp_valid`. An enable 1-to-0 write pulses `disarm_strobe` for one cycle.
- R8: `legacy_mode` equals configuration bit 1. It rises when that bit is written to 1 and falls when it is written to 0.
- R9: Offset 0x020 reads `chan_irq_status` zero-extended. Writes there have no effect.
- R10: Reads of undefined or misaligned offsets return zero. Writes to them change no register.
- R11: After reset the counter, the configuration, `rsp_valid` and both strobes are zero.
- R12: While enabled with `cnt_tick` low, the counter holds.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low asynchronous reset |
| req_valid | input | 1 | Access request this cycle |
| req_write | input | 1 | 1 = write, 0 = read |
| req_addr | input | 10 | Byte address in the window |
| req_wdata | input | 32 | Write data |
| rsp_valid | output | 1 | Read data valid |
| rsp_rdata | output | 32 | Read data |
| cnt_tick | input | 1 | Counter advance qualifier |
| chan_sel | output | NUM_CH | One-hot channel select |
| chan_wr | output | 1 | Channel access is a write |
| chan_off | output | 5 | Offset inside the channel group |
| chan_wdata | output | 32 | Write data to channels |
| chan_rdata | input | NUM_CH*32 | Per-channel read data |
| chan_cmp_valid | input | NUM_CH | Channel comparator is not all ones |
| chan_irq_status | input | NUM_CH | Channel interrupt status |
| main_count | output | 64 | Main counter value |
| glb_enable | output | 1 | Global enable |
| legacy_mode | output | 1 | Legacy routing; legacy timers disabled |
| arm_strobe | output | NUM_CH | Per-channel arm pulse |
| disarm_strobe | output | 1 | Disarm-all pulse |

## Verification
The bench presets the counter just below a 32-bit boundary and runs it, so that a design which loses the carry into the high half reads back a wrong high word. A counter write is issued while running, which catches a design that lets presets through at any time. It also counts the exact edges between START and STOP, which exposes an off-by-one at either transition. Further stimulus covers the channel index just past the last implemented one, misaligned and undefined offsets, masked configuration bits, and enabling with the tick held low. A design that got these wrong would alias a phantom channel, corrupt the configuration, or let the counter drift.

// File: rtl/evt_timer_pkg.sv
package evt_timer_pkg;

    localparam int WIN_AW  = 10;
    localparam int HALF_W  = 32;
    localparam int OFF_W   = 5;
    localparam int GRP_W   = WIN_AW - OFF_W;

    localparam logic [WIN_AW-1:0] OFS_CAP_LO = 10'h000;
    localparam logic [WIN_AW-1:0] OFS_CAP_HI = 10'h004;
    localparam logic [WIN_AW-1:0] OFS_CFG    = 10'h010;
    localparam logic [WIN_AW-1:0] OFS_CFG_HI = 10'h014;
    localparam logic [WIN_AW-1:0] OFS_STAT   = 10'h020;
    localparam logic [WIN_AW-1:0] OFS_CNT_LO = 10'h0F0;
    localparam logic [WIN_AW-1:0] OFS_CNT_HI = 10'h0F4;
    localparam logic [WIN_AW-1:0] CHAN_BASE  = 10'h100;

    typedef enum logic [3:0] {
        RG_NONE,
        RG_CAP_LO,
        RG_CAP_HI,
        RG_CFG,
        RG_CFG_HI,
        RG_STATUS,
        RG_CNT_LO,
        RG_CNT_HI,
        RG_CHAN
    } evt_region_e;

    typedef enum logic {
        CTR_HALTED,
        CTR_RUNNING
    } ctr_state_e;

endpackage

// File: rtl/evt_addr_decode.sv
module evt_addr_decode
    import evt_timer_pkg::*;
#(
    parameter int NUM_CH = 3
) (
    input  logic [WIN_AW-1:0] addr,
    output evt_region_e       region,
    output logic [GRP_W-1:0]  chan_idx,
    output logic              chan_hit
);
    localparam logic [GRP_W-1:0] BASE_GRP = CHAN_BASE[WIN_AW-1:OFF_W];

    always_comb begin
        region   = RG_NONE;
        chan_idx = addr[WIN_AW-1:OFF_W] - BASE_GRP;
        chan_hit = 1'b0;
        if (addr[1:0] == 2'b00) begin
            if (addr >= CHAN_BASE) begin
                region   = RG_CHAN;
                chan_hit = (32'(chan_idx) < NUM_CH);
            end else begin
                unique case (addr)
                    OFS_CAP_LO: region = RG_CAP_LO;
                    OFS_CAP_HI: region = RG_CAP_HI;
                    OFS_CFG:    region = RG_CFG;
                    OFS_CFG_HI: region = RG_CFG_HI;
                    OFS_STAT:   region = RG_STATUS;
                    OFS_CNT_LO: region = RG_CNT_LO;
                    OFS_CNT_HI: region = RG_CNT_HI;
                    default:    region = RG_NONE;
                endcase
            end
        end
    end
endmodule

// File: rtl/evt_main_counter.sv
module evt_main_counter
    import evt_timer_pkg::*;
#(
    parameter int NUM_CH = 3
) (
    input  logic                clk,
    input  logic                rst_n,
    input  logic                tick,
    input  logic                en_next,
    input  logic                wr_lo,
    input  logic                wr_hi,
    input  logic [HALF_W-1:0]   wdata,
    input  logic [NUM_CH-1:0]   cmp_valid,
    output logic [2*HALF_W-1:0] count,
    output logic                running,
    output logic [NUM_CH-1:0]   arm,
    output logic                disarm
);
    ctr_state_e state_q, state_d;
    logic [2*HALF_W-1:0] cnt_q;
    logic [NUM_CH-1:0]   arm_q;
    logic                disarm_q;
    logic                go_start, go_stop;

    // Next-state: START when enabled from halt, STOP when disabled while running.
    always_comb begin
        state_d  = state_q;
        go_start = 1'b0;
        go_stop  = 1'b0;
        unique case (state_q)
            CTR_HALTED: if (en_next) begin
                state_d  = CTR_RUNNING;
                go_start = 1'b1;
            end
            CTR_RUNNING: if (!en_next) begin
                state_d = CTR_HALTED;
                go_stop = 1'b1;
            end
            default: state_d = CTR_HALTED;
        endcase
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) state_q <= CTR_HALTED;
        else        state_q <= state_d;
    end

    // Output process: counter datapath and transition strobes.
    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            cnt_q    <= '0;
            arm_q    <= '0;
            disarm_q <= 1'b0;
        end else begin
            arm_q    <= go_start ? cmp_valid : '0;
            disarm_q <= go_stop;
            unique case (state_q)
                CTR_HALTED: begin
                    if (wr_lo) cnt_q[HALF_W-1:0]        <= wdata;
                    if (wr_hi) cnt_q[2*HALF_W-1:HALF_W] <= wdata;
                end
                CTR_RUNNING: if (tick) cnt_q <= cnt_q + 1'b1;
                default: ;
            endcase
        end
    end

    assign count   = cnt_q;
    assign running = (state_q == CTR_RUNNING);
    assign arm     = arm_q;
    assign disarm  = disarm_q;

    p_hold_halted_r5: assert property (@(posedge clk) disable iff (!rst_n)
        (state_q == CTR_HALTED && !wr_lo && !wr_hi) |=> $stable(cnt_q));
    p_step_running_r5: assert property (@(posedge clk) disable iff (!rst_n)
        (state_q == CTR_RUNNING && tick) |=> (cnt_q == $past(cnt_q) + 64'd1));
    p_no_tick_hold_r12: assert property (@(posedge clk) disable iff (!rst_n)
        (state_q == CTR_RUNNING && !tick) |=> $stable(cnt_q));
    p_arm_on_start_r7: assert property (@(posedge clk) disable iff (!rst_n)
        (|arm_q) |-> ($past(state_q) == CTR_HALTED && state_q == CTR_RUNNING));
    p_disarm_pulse_r7: assert property (@(posedge clk) disable iff (!rst_n)
        disarm_q |=> !disarm_q);
endmodule

// File: rtl/evt_read_mux.sv
module evt_read_mux
    import evt_timer_pkg::*;
#(
    parameter int NUM_CH = 3,
    parameter logic [HALF_W-1:0] CAP_LO = '0,
    parameter logic [HALF_W-1:0] CAP_HI = '0
) (
    input  evt_region_e              region,
    input  logic [GRP_W-1:0]         chan_idx,
    input  logic                     chan_hit,
    input  logic [HALF_W-1:0]        cfg,
    input  logic [2*HALF_W-1:0]      count,
    input  logic [NUM_CH-1:0]        irq_status,
    input  logic [NUM_CH*HALF_W-1:0] chan_rdata,
    output logic [HALF_W-1:0]        rdata
);
    logic [HALF_W-1:0] chan_word;

    always_comb begin
        chan_word = '0;
        for (int i = 0; i < NUM_CH; i++) begin
            if (32'(chan_idx) == i) chan_word = chan_rdata[i*HALF_W +: HALF_W];
        end
    end

    always_comb begin
        unique case (region)
            RG_CAP_LO: rdata = CAP_LO;
            RG_CAP_HI: rdata = CAP_HI;
            RG_CFG:    rdata = cfg;
            RG_STATUS: rdata = HALF_W'(irq_status);
            RG_CNT_LO: rdata = count[HALF_W-1:0];
            RG_CNT_HI: rdata = count[2*HALF_W-1:HALF_W];
            RG_CHAN:   rdata = chan_hit ? chan_word : '0;
            default:   rdata = '0;
        endcase
    end
endmodule

// File: rtl/evt_timer_regs.sv
module evt_timer_regs
    import evt_timer_pkg::*;
#(
    parameter int                NUM_CH    = 3,
    parameter logic [31:0]       TICK_FS   = 32'd10000000,
    parameter logic [15:0]       VENDOR_ID = 16'h8086,
    parameter logic [7:0]        REV_ID    = 8'h01,
    parameter logic [31:0]       CFG_WMASK = 32'h0000_0003
) (
    input  logic                     clk,
    input  logic                     rst_n,
    input  logic                     req_valid,
    input  logic                     req_write,
    input  logic [9:0]               req_addr,
    input  logic [31:0]              req_wdata,
    output logic                     rsp_valid,
    output logic [31:0]              rsp_rdata,
    input  logic                     cnt_tick,
    output logic [NUM_CH-1:0]        chan_sel,
    output logic                     chan_wr,
    output logic [4:0]               chan_off,
    output logic [31:0]              chan_wdata,
    input  logic [NUM_CH*32-1:0]     chan_rdata,
    input  logic [NUM_CH-1:0]        chan_cmp_valid,
    input  logic [NUM_CH-1:0]        chan_irq_status,
    output logic [63:0]              main_count,
    output logic                     glb_enable,
    output logic                     legacy_mode,
    output logic [NUM_CH-1:0]        arm_strobe,
    output logic                     disarm_strobe
);
    localparam int CFG_EN_BIT  = 0;
    localparam int CFG_LEG_BIT = 1;
    localparam logic [4:0]  NCH_FIELD = 5'(NUM_CH - 1);
    localparam logic [31:0] CAP_WORD  = {VENDOR_ID, 1'b1, 1'b0, 1'b1, NCH_FIELD, REV_ID};

    evt_region_e       region;
    logic [GRP_W-1:0]  chan_idx;
    logic              chan_hit;
    logic [31:0]       cfg_q, cfg_d;
    logic              cfg_wr, cnt_wr_lo, cnt_wr_hi, rd_req;
    logic [31:0]       rd_word;
    logic              running;

    evt_addr_decode #(.NUM_CH(NUM_CH)) u_dec (
        .addr     (req_addr),
        .region   (region),
        .chan_idx (chan_idx),
        .chan_hit (chan_hit)
    );

    assign cfg_wr    = req_valid && req_write && (region == RG_CFG);
    assign cnt_wr_lo = req_valid && req_write && (region == RG_CNT_LO);
    assign cnt_wr_hi = req_valid && req_write && (region == RG_CNT_HI);
    assign rd_req    = req_valid && !req_write;
    assign cfg_d     = cfg_wr ? ((cfg_q & ~CFG_WMASK) | (req_wdata & CFG_WMASK)) : cfg_q;

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) cfg_q <= '0;
        else        cfg_q <= cfg_d;
    end

    evt_main_counter #(.NUM_CH(NUM_CH)) u_ctr (
        .clk       (clk),
        .rst_n     (rst_n),
        .tick      (cnt_tick),
        .en_next   (cfg_d[CFG_EN_BIT]),
        .wr_lo     (cnt_wr_lo),
        .wr_hi     (cnt_wr_hi),
        .wdata     (req_wdata),
        .cmp_valid (chan_cmp_valid),
        .count     (main_count),
        .running   (running),
        .arm       (arm_strobe),
        .disarm    (disarm_strobe)
    );

    evt_read_mux #(.NUM_CH(NUM_CH), .CAP_LO(CAP_WORD), .CAP_HI(TICK_FS)) u_rmux (
        .region     (region),
        .chan_idx   (chan_idx),
        .chan_hit   (chan_hit),
        .cfg        (cfg_q),
        .count      (main_count),
        .irq_status (chan_irq_status),
        .chan_rdata (chan_rdata),
        .rdata      (rd_word)
    );

    // Channel select fan-out, one bit per implemented channel.
    for (genvar g = 0; g < NUM_CH; g++) begin : g_sel
        assign chan_sel[g] = req_valid && (region == RG_CHAN) && chan_hit
                             && (32'(chan_idx) == g);
    end
    assign chan_wr    = req_write;
    assign chan_off   = req_addr[OFF_W-1:0];
    assign chan_wdata = req_wdata;

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            rsp_valid <= 1'b0;
            rsp_rdata <= '0;
        end else begin
            rsp_valid <= rd_req;
            rsp_rdata <= rd_req ? rd_word : '0;
        end
    end

    assign glb_enable  = running;
    assign legacy_mode = cfg_q[CFG_LEG_BIT];

    p_sel_onehot_r1: assert property (@(posedge clk) disable iff (!rst_n)
        $onehot0(chan_sel));
    p_read_resp_r2: assert property (@(posedge clk) disable iff (!rst_n)
        rd_req |=> rsp_valid);
    p_no_write_resp_r2: assert property (@(posedge clk) disable iff (!rst_n)
        !rd_req |=> !rsp_valid);
    p_cfg_write_only_r4: assert property (@(posedge clk) disable iff (!rst_n)
        !cfg_wr |=> $stable(cfg_q));
    p_legacy_follow_r8: assert property (@(posedge clk) disable iff (!rst_n)
        !$stable(legacy_mode) |-> $past(cfg_wr));
    p_enable_match_r5: assert property (@(posedge clk) disable iff (!rst_n)
        glb_enable == cfg_q[CFG_EN_BIT]);
endmodule

// File: tb/sim_evt_timer_regs.sv
`timescale 1ns/1ps
module sim_evt_timer_regs;
    localparam int NCH = 3;

    logic clk = 1'b0;
    logic rst_n = 1'b0;
    logic req_valid = 1'b0, req_write = 1'b0;
    logic [9:0]  req_addr = '0;
    logic [31:0] req_wdata = '0;
    logic rsp_valid;
    logic [31:0] rsp_rdata;
    logic cnt_tick = 1'b1;
    logic [NCH-1:0] chan_sel;
    logic chan_wr;
    logic [4:0] chan_off;
    logic [31:0] chan_wdata;
    logic [NCH*32-1:0] chan_rdata;
    logic [NCH-1:0] chan_cmp_valid = '0;
    logic [NCH-1:0] chan_irq_status = '0;
    logic [63:0] main_count;
    logic glb_enable, legacy_mode, disarm_strobe;
    logic [NCH-1:0] arm_strobe;

    int checks = 0;
    int errors = 0;
    logic [31:0] exp_q[$];
    string       tag_q[$];

    always #2 clk = ~clk;

    // Simple channel model: data encodes channel index and offset.
    for (genvar g = 0; g < NCH; g++) begin : g_chan
        assign chan_rdata[g*32 +: 32] = {24'hC4A000 + 24'(g), 3'b000, chan_off};
    end

    evt_timer_regs u0 (
        .clk(clk), .rst_n(rst_n), .req_valid(req_valid), .req_write(req_write),
        .req_addr(req_addr), .req_wdata(req_wdata), .rsp_valid(rsp_valid),
        .rsp_rdata(rsp_rdata), .cnt_tick(cnt_tick), .chan_sel(chan_sel),
        .chan_wr(chan_wr), .chan_off(chan_off), .chan_wdata(chan_wdata),
        .chan_rdata(chan_rdata), .chan_cmp_valid(chan_cmp_valid),
        .chan_irq_status(chan_irq_status), .main_count(main_count),
        .glb_enable(glb_enable), .legacy_mode(legacy_mode),
        .arm_strobe(arm_strobe), .disarm_strobe(disarm_strobe)
    );

    task automatic check(input string req, input logic [63:0] act, input logic [63:0] exp);
        checks++;
        if (act !== exp) begin
            errors++;
            $display("FAIL %s actual=%h expected=%h", req, act, exp);
        end
    endtask

    // Monitor: pops expected read data as responses appear.
    always @(negedge clk) begin
        if (rst_n && rsp_valid) begin
            if (exp_q.size() == 0) begin
                check("R2 unexpected response", 64'(rsp_rdata), 64'hDEAD);
            end else begin
                logic [31:0] e;
                string t;
                e = exp_q.pop_front();
                t = tag_q.pop_front();
                check(t, 64'(rsp_rdata), 64'(e));
            end
        end
    end

    task automatic wr(input logic [9:0] a, input logic [31:0] d);
        req_valid = 1'b1; req_write = 1'b1; req_addr = a; req_wdata = d;
        @(negedge clk);
        req_valid = 1'b0; req_write = 1'b0;
    endtask

    task automatic rd(input logic [9:0] a, input logic [31:0] e, input string t);
        exp_q.push_back(e);
        tag_q.push_back(t);
        req_valid = 1'b1; req_write = 1'b0; req_addr = a;
        @(negedge clk);
        req_valid = 1'b0;
    endtask

    task automatic idle(input int n);
        repeat (n) @(negedge clk);
    endtask

    initial begin
        #(200000 * 4);
        errors++;
        $display("FAIL watchdog expired");
        $display("  CHECKS %0d ERRORS %0d", checks, errors);
        $finish;
    end

    initial begin
        repeat (3) @(negedge clk);
        rst_n = 1'b1;
        @(negedge clk);
        // R11 reset state
        check("R11 count", main_count, 64'h0);
        check("R11 enable", 64'(glb_enable), 64'h0);
        check("R11 legacy", 64'(legacy_mode), 64'h0);
        check("R11 strobes", 64'({arm_strobe, disarm_strobe, rsp_valid}), 64'h0);
        rd(10'h010, 32'h0, "R11 cfg");

        // R3 capability
        rd(10'h000, 32'h8086A201, "R3 cap lo");
        rd(10'h004, 32'd10000000, "R3 cap hi");
        wr(10'h000, 32'h0);
        wr(10'h004, 32'h0);
        rd(10'h000, 32'h8086A201, "R3 cap lo after write");
        rd(10'h004, 32'd10000000, "R3 cap hi after write");

        // R4 masked configuration
        wr(10'h010, 32'hFFFF_FFFC);
        rd(10'h010, 32'h0, "R4 masked bits");
        wr(10'h014, 32'hFFFF_FFFF);
        rd(10'h014, 32'h0, "R4 cfg hi");
        check("R4 enable untouched", 64'(glb_enable), 64'h0);

        // R9 status
        chan_irq_status = 3'b110;
        rd(10'h020, 32'h6, "R9 status");
        wr(10'h020, 32'hFFFF_FFFF);
        rd(10'h020, 32'h6, "R9 status after write");

        // R6 preset halves while halted
        wr(10'h0F0, 32'hFFFF_FFFC);
        wr(10'h0F4, 32'h0000_0005);
        rd(10'h0F0, 32'hFFFF_FFFC, "R6 lo kept");
        rd(10'h0F4, 32'h5, "R6 hi");
        wr(10'h0F4, 32'h0000_0001);
        rd(10'h0F0, 32'hFFFF_FFFC, "R6 lo after hi write");
        check("R6 count port", main_count, 64'h1_FFFF_FFFC);

        // R7 START, R6 ignored write while running, R5 exact count
        chan_cmp_valid = 3'b101;
        wr(10'h010, 32'h1);
        check("R7 arm strobe", 64'(arm_strobe), 64'h5);
        check("R5 enable out", 64'(glb_enable), 64'h1);
        wr(10'h0F0, 32'h0000_0055);
        check("R7 arm one cycle", 64'(arm_strobe), 64'h0);
        idle(4);
        wr(10'h010, 32'h0);
        check("R7 disarm strobe", 64'(disarm_strobe), 64'h1);
        rd(10'h0F0, 32'h0000_0002, "R5 R6 lo after run");
        check("R7 disarm one cycle", 64'(disarm_strobe), 64'h0);
        rd(10'h0F4, 32'h0000_0002, "R5 hi carry");
        check("R5 count port", main_count, 64'h2_0000_0002);

        // R12 tick low holds counter
        cnt_tick = 1'b0;
        wr(10'h010, 32'h1);
        idle(3);
        wr(10'h010, 32'h0);
        cnt_tick = 1'b1;
        rd(10'h0F0, 32'h0000_0002, "R12 held");

        // R8 legacy
        wr(10'h010, 32'h2);
        check("R8 legacy set", 64'(legacy_mode), 64'h1);
        check("R8 no enable", 64'(glb_enable), 64'h0);
        wr(10'h010, 32'h0);
        check("R8 legacy clear", 64'(legacy_mode), 64'h0);

        // R10 undefined and misaligned
        wr(10'h030, 32'hFFFF_FFFF);
        wr(10'h0F8, 32'hFFFF_FFFF);
        wr(10'h0F1, 32'hFFFF_FFFF);
        wr(10'h011, 32'hFFFF_FFFF);
        rd(10'h030, 32'h0, "R10 undefined read");
        rd(10'h0F2, 32'h0, "R10 misaligned read");
        rd(10'h010, 32'h0, "R10 cfg intact");
        rd(10'h0F0, 32'h0000_0002, "R10 counter intact");

        // R1 channel decode
        req_valid = 1'b1; req_write = 1'b1; req_addr = 10'h148; req_wdata = 32'hABCD;
        #1;
        check("R1 sel ch2", 64'(chan_sel), 64'h4);
        check("R1 offset", 64'(chan_off), 64'h08);
        check("R1 wdata", 64'({chan_wr, chan_wdata}), 64'h1_0000ABCD);
        @(negedge clk);
        req_valid = 1'b0; req_write = 1'b0;
        rd(10'h148, 32'hC4A00208, "R1 ch2 read");
        rd(10'h104, 32'hC4A00004, "R1 ch0 read");
        req_valid = 1'b1; req_write = 1'b0; req_addr = 10'h160;
        exp_q.push_back(32'h0); tag_q.push_back("R1 past last channel");
        #1;
        check("R1 no sel past last", 64'(chan_sel), 64'h0);
        @(negedge clk);
        req_valid = 1'b0;

        idle(3);
        check("R2 all responses seen", 64'(exp_q.size()), 64'h0);
        $display("  CHECKS %0d ERRORS %0d", checks, errors);
        $finish;
    end
endmodule